// File: doc/BRIEF.md
# Dual-Mode Baud Rate Generator

This block divides the system clock by a 16-bit divisor to pace a UART. Software loads the divisor one byte at a time through a small register write port, and the block answers with a periodic sample tick. From that tick it derives a bit tick. In standard mode the bit tick comes once every sixteen sample ticks, which suits a receiver that oversamples each bit 16 times. In LIN mode every sample tick is also a bit tick, so the bit rate is the clock divided by the divisor.

The same down-counter doubles as a general interval timer. When the receiver enable is low and the timer control input is high, every time-out also sets a sticky interrupt flag. Software clears that flag with a write-one-to-clear. The counter runs whenever the receiver, the transmitter or the timer is enabled. Transmission can therefore carry on while the block times intervals.

Top module: `rate_divider`

## Requirements
- R1: The counter runs while any of rxEnable, txEnable or timerCtl is 1. While all three are 0, no tick is produced and the count is held at zero. The first clock edge after the counter starts produces a sample tick.
- R2: The divisor is {high byte, low byte}. Register address 0 writes bits 7:0 and address 1 writes bits 15:8. Successive sample ticks, each one clock wide, are exactly divisor clocks apart.
- R3: With linMode 0, bitTick pulses together with every 16th sample tick, so bit ticks are 16 × divisor clocks apart. bitTick never pulses without sampleTick.
- R4: With linMode 1, bitTick pulses together with every sample tick.
- R5: A divisor of 0 gives a period of 65536 clocks. A divisor of 1 gives a tick on every clock.
- R6: Writing a divisor byte leaves the count in progress untouched. The new value sets the length of the period that begins at the next tick.
- R7: Timer mode is rxEnable 0 with timerCtl 1. Only a time-out in timer mode sets irq. Sample ticks keep running in timer mode.
- R8: irq stays set until a write to address 2 with data bit 0 equal to 1. If a time-out falls in the same clock as that clear, irq stays set.
- R9: Reset clears both divisor bytes, the counter, the tick outputs and irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | 0 divisor low, 1 divisor high, 2 interrupt clear |
| wrData | input | 8 | Write data |
| rxEnable | input | 1 | Receiver enable; 0 allows timer mode |
| txEnable | input | 1 | Transmitter enable; keeps the counter running |
| linMode | input | 1 | 1 selects one tick per bit |
| timerCtl | input | 1 | Timer and interrupt enable, used only while rxEnable is 0 |
| sampleTick | output | 1 | One-clock pulse every divisor clocks |
| bitTick | output | 1 | One-clock pulse once per bit |
| irq | output | 1 | Sticky timer time-out flag |

## Verification
The divisor is tried at its extremes: the reset value 0 gives 65536 clocks, 1 gives a tick on every clock, and a value with a nonzero high byte shows that both bytes count. Random small divisors are run in both modes, which separates the 16x bit spacing from the 1x bit spacing. A divisor write in the middle of a period shows whether the new value is applied at once or at the next reload. Timer runs with the receiver on and off, and with a clear landing on a time-out, separate the set, hold and clear priorities of irq.

// File: rtl/rate_divider_pkg.sv
package rate_divider_pkg;
  localparam logic [1:0] ADDR_DIV_LO = 2'd0;
  localparam logic [1:0] ADDR_DIV_HI = 2'd1;
  localparam logic [1:0] ADDR_IRQ_CLR = 2'd2;

  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic irqClr;
    logic run;
    logic lin;
    logic timerMode;
  } strobe_t;
endpackage

// File: rtl/rate_divider_ctrl.sv
module rate_divider_ctrl
  import rate_divider_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       clrBit,
  input  logic       rxEnable,
  input  logic       txEnable,
  input  logic       linMode,
  input  logic       timerCtl,
  output strobe_t    stb
);
  always_comb begin
    stb.wrLow     = wrEn && (wrAddr == ADDR_DIV_LO);
    stb.wrHigh    = wrEn && (wrAddr == ADDR_DIV_HI);
    stb.irqClr    = wrEn && (wrAddr == ADDR_IRQ_CLR) && clrBit;
    stb.run       = rxEnable || txEnable || timerCtl;
    stb.lin       = linMode;
    stb.timerMode = !rxEnable && timerCtl;
  end
endmodule

// File: rtl/rate_divider_dp.sv
module rate_divider_dp
  import rate_divider_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic              sampleTick,
  output logic              bitTick,
  output logic              irq
);
  localparam int HI_W  = DIV_W - BYTE_W;
  localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

  logic [BYTE_W-1:0] divLo;
  logic [HI_W-1:0]   divHi;
  logic [DIV_W-1:0]  divisor;
  logic [DIV_W-1:0]  reloadVal;
  logic [DIV_W-1:0]  count;
  logic [OVS_W-1:0]  ovsCount;
  logic              expire;

  assign divisor   = {divHi, divLo};
  assign reloadVal = divisor - DIV_W'(1);
  assign expire    = stb.run && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo <= '0;
      divHi <= '0;
    end else begin
      if (stb.wrLow)  divLo <= wrData;
      if (stb.wrHigh) divHi <= wrData[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      ovsCount   <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else if (!stb.run) begin
      count      <= '0;
      ovsCount   <= '0;
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end else if (expire) begin
      count      <= reloadVal;
      sampleTick <= 1'b1;
      if (stb.lin) begin
        bitTick  <= 1'b1;
        ovsCount <= '0;
      end else begin
        bitTick  <= (ovsCount == OVS_LAST);
        ovsCount <= (ovsCount == OVS_LAST) ? '0 : ovsCount + OVS_W'(1);
      end
    end else begin
      count      <= count - DIV_W'(1);
      sampleTick <= 1'b0;
      bitTick    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        irq <= 1'b0;
    else if (expire && stb.timerMode) irq <= 1'b1;
    else if (stb.irqClr)              irq <= 1'b0;
  end
endmodule

// File: rtl/rate_divider.sv
module rate_divider
  import rate_divider_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rxEnable,
  input  logic              txEnable,
  input  logic              linMode,
  input  logic              timerCtl,
  output logic              sampleTick,
  output logic              bitTick,
  output logic              irq
);
  strobe_t stb;

  rate_divider_ctrl u_ctrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .clrBit   (wrData[0]),
    .rxEnable (rxEnable),
    .txEnable (txEnable),
    .linMode  (linMode),
    .timerCtl (timerCtl),
    .stb      (stb)
  );

  rate_divider_dp #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .OVS(OVS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (wrData),
    .sampleTick (sampleTick),
    .bitTick    (bitTick),
    .irq        (irq)
  );
endmodule

// File: rtl/rate_divider_chk.sv
module rate_divider_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       clrBit,
  input logic       rxEnable,
  input logic       txEnable,
  input logic       linMode,
  input logic       timerCtl,
  input logic       sampleTick,
  input logic       bitTick,
  input logic       irq
);
  assert_tick_needs_run_R1: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> $past(rxEnable || txEnable || timerCtl));

  assert_bit_within_sample_R3: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> sampleTick);

  assert_lin_every_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && $past(linMode)) |-> bitTick);

  assert_irq_from_timer_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(!rxEnable && timerCtl) && sampleTick));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(wrEn && wrAddr == 2'd2 && clrBit)) |=> irq);
endmodule

bind rate_divider rate_divider_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .clrBit     (wrData[0]),
  .rxEnable   (rxEnable),
  .txEnable   (txEnable),
  .linMode    (linMode),
  .timerCtl   (timerCtl),
  .sampleTick (sampleTick),
  .bitTick    (bitTick),
  .irq        (irq)
);

// File: tb/rate_divider_bench.sv
module rate_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       rxEnable = 1'b0;
  logic       txEnable = 1'b0;
  logic       linMode = 1'b0;
  logic       timerCtl = 1'b0;
  logic       sampleTick, bitTick, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  rate_divider u_rate_divider (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rxEnable(rxEnable), .txEnable(txEnable), .linMode(linMode),
    .timerCtl(timerCtl), .sampleTick(sampleTick), .bitTick(bitTick), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint expPeriod(input int div);
    return (div == 0) ? 65536 : div;
  endfunction

  function automatic longint expBit(input int div, input bit lin);
    return lin ? expPeriod(div) : 16 * expPeriod(div);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setDiv(input int div);
    writeReg(2'd0, div[7:0]);
    writeReg(2'd1, div[15:8]);
  endtask

  task automatic waitTick(input bit useBit);
    do @(negedge clk); while (!(useBit ? bitTick : sampleTick));
  endtask

  task automatic measure(input bit useBit, output longint n);
    waitTick(useBit);
    n = 0;
    do begin @(negedge clk); n++; end while (!(useBit ? bitTick : sampleTick));
  endtask

  task automatic stopAll();
    @(negedge clk);
    rxEnable = 1'b0; txEnable = 1'b0; timerCtl = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    longint n;
    int seen;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: outputs idle after reset
    check("R9 sampleTick after reset", sampleTick, 0);
    check("R9 irq after reset", irq, 0);

    // R9 / R5: reset divisor is 0, giving 65536 clocks
    linMode = 1'b1; rxEnable = 1'b1;
    measure(1'b0, n);
    check("R5 R9 divisor zero period", n, expPeriod(0));

    // R1: idle produces no tick, restart ticks on first edge
    stopAll();
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sampleTick || bitTick) seen++;
    end
    check("R1 no tick while idle", seen, 0);
    rxEnable = 1'b1;
    @(negedge clk);
    check("R1 tick on first edge after start", sampleTick, 1);

    // R5: divisor 1 in LIN mode ticks every clock
    stopAll();
    setDiv(1);
    rxEnable = 1'b1;
    measure(1'b1, n);
    check("R5 divisor one interval", n, 1);

    // R2: high byte counts
    stopAll();
    setDiv(258);
    linMode = 1'b0; rxEnable = 1'b1;
    measure(1'b0, n);
    check("R2 two-byte divisor period", n, expPeriod(258));

    // R6: write mid-period does not disturb the count
    stopAll();
    setDiv(20);
    rxEnable = 1'b1;
    waitTick(1'b0);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'd7;
    n = 0;
    do begin
      @(negedge clk); n++; wrEn = 1'b0;
    end while (!sampleTick);
    check("R6 period in progress keeps old divisor", n, 20);
    n = 0;
    do begin @(negedge clk); n++; end while (!sampleTick);
    check("R6 next period uses new divisor", n, 7);

    // R2 R3 R4: random divisors in both modes
    for (int k = 0; k < 6; k++) begin
      int div;
      bit lin;
      div = 1 + int'($urandom % 40);
      lin = 1'($urandom % 2);
      stopAll();
      setDiv(div);
      linMode = lin; rxEnable = 1'b1;
      measure(1'b0, n);
      check("R2 random sample period", n, expPeriod(div));
      measure(1'b1, n);
      check(lin ? "R4 random LIN bit period" : "R3 random 16x bit period", n, expBit(div, lin));
    end

    // R7 / R8: timer mode with transmitter active
    stopAll();
    setDiv(50);
    linMode = 1'b1;
    @(negedge clk);
    timerCtl = 1'b1; txEnable = 1'b1;
    waitTick(1'b0);
    check("R7 irq set at time-out", irq, 1);
    writeReg(2'd2, 8'h01);
    check("R8 irq cleared by write one", irq, 0);
    waitTick(1'b0);
    check("R8 irq set again at next time-out", irq, 1);
    repeat (10) @(negedge clk);
    check("R8 irq holds until cleared", irq, 1);
    writeReg(2'd2, 8'h00);
    check("R8 write of zero leaves irq set", irq, 1);
    measure(1'b0, n);
    check("R7 ticks continue in timer mode", n, 50);

    // R7: receiver enabled blocks timer interrupt
    @(negedge clk);
    rxEnable = 1'b1;
    writeReg(2'd2, 8'h01);
    check("R7 irq clear with receiver on", irq, 0);
    measure(1'b0, n);
    measure(1'b0, n);
    check("R7 no irq while receiver enabled", irq, 0);

    // R8: clear coinciding with a time-out keeps irq set
    stopAll();
    setDiv(1);
    timerCtl = 1'b1;
    repeat (3) @(negedge clk);
    writeReg(2'd2, 8'h01);
    check("R8 time-out wins over clear", irq, 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule